// File: doc/BRIEF.md
# Three-stage physical register file with in-flight write forwarding

This block is a shared physical register file for an out-of-order core. Every operand class uses it as one common pool of entries. Both reads and writes move through three pipeline stages, so a read would otherwise miss writes that have been issued but not yet committed to the storage rows. A forwarding network compares each read against every write still in flight and supplies the newest matching value. A consumer therefore always sees the most recent write issued before its own read.

A read port presents a valid bit and an index in its issue cycle. The result and a result-valid flag appear three clock edges later. A write port presents a valid bit, an index and data in its issue cycle. The storage row is updated at the end of its third write stage.

Indices at or above the entry count are rejected at the ports. Valid write ports must use distinct indices within a cycle. Entry count, data width and the number of read and write ports are parameters. The defaults are 160 entries of 64 bits, 8 read ports and 4 write ports.

Top module: `staged_regfile`

## Requirements
- R1: After reset, `rd_ok` is all low and `rd_data` is all zero. Every entry reads as zero until it is first written.
- R2: A read issued in cycle c gives its result in cycle c+3, after three rising edges. `rd_ok` bit p is high in cycle c+3 exactly when `rd_vld` bit p was high in cycle c with an index below the entry count. Whenever `rd_ok` bit p is low, data slice p is zero.
- R3: A read returns the data of the youngest write to its index issued in an earlier cycle. This includes a write issued just one cycle before the read. Reading one index in back-to-back cycles with no write issued in the first of those cycles gives identical data.
- R4: A write issued two or three cycles before a read to the same index is seen by that read.
- R5: A write issued four or more cycles before a read is returned from the storage rows, and it persists until overwritten.
- R6: A write issued in the same cycle as a read to the same index has no effect on that read's result. The read returns the older value.
- R7: When two or three writes to one index are in flight at once, a read returns the data of the one issued last.
- R8: A read with index at or above the entry count gives `rd_ok` low and zero data. A write with such an index is dropped and changes no entry.
- R9: All write ports may write distinct indices in the same cycle, and all take effect. All read ports operate independently. Two valid write ports must not target the same in-range index in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| rd_vld | input | NR | Read request valid, one bit per read port |
| rd_idx | input | NR*IW | Read indices, port p at bits p*IW +: IW |
| wr_vld | input | NW | Write request valid, one bit per write port |
| wr_idx | input | NW*IW | Write indices, port w at bits w*IW +: IW |
| wr_data | input | NW*DW | Write data, port w at bits w*DW +: DW |
| rd_ok | output | NR | Result valid, three cycles after the read |
| rd_data | output | NR*DW | Read results, port p at bits p*DW +: DW, zero when not valid |

## Verification
The bench attacks the boundary between in-flight and committed writes. It reads one index at every age from zero to five cycles after a write.

A design whose forwarding missed one write stage would return stale data at exactly one of those ages. A design that let same-cycle writes forward would fail the zero-age read. Back-to-back writes to one index from different ports catch a priority mux that favours an older stage.

Out-of-range reads must show a low valid flag and zero data. A mass concurrent write on all ports exposes a storage update that drops a port.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Depth of both the read and the write pipeline.
  localparam int unsigned STAGES = 3;

endpackage

// File: rtl/prf_wr_pipe.sv
module prf_wr_pipe
  import sfr_pkg::*;
#(
  parameter int unsigned NW = 4,
  parameter int unsigned IW = 8,
  parameter int unsigned DW = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NW-1:0]                       in_vld,
  input  logic [NW-1:0][IW-1:0]               in_idx,
  input  logic [NW-1:0][DW-1:0]               in_data,
  output logic [STAGES-1:0][NW-1:0]           st_vld,
  output logic [STAGES-1:0][NW-1:0][IW-1:0]   st_idx,
  output logic [STAGES-1:0][NW-1:0][DW-1:0]   st_data
);

  logic [STAGES-1:0][NW-1:0]         v_d, v_q;
  logic [STAGES-1:0][NW-1:0][IW-1:0] i_d, i_q;
  logic [STAGES-1:0][NW-1:0][DW-1:0] d_d, d_q;

  // Next state: stage 0 takes the port, deeper stages shift.
  always_comb begin
    v_d[0] = in_vld;
    i_d[0] = in_idx;
    d_d[0] = in_data;
    for (int s = 1; s < int'(STAGES); s++) begin
      v_d[s] = v_q[s-1];
      i_d[s] = i_q[s-1];
      d_d[s] = d_q[s-1];
    end
  end

  // Valid bits carry reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_d;
    end
  end

  // Payload registers are enabled by the incoming valid bit only.
  always_ff @(posedge clk) begin
    for (int s = 0; s < int'(STAGES); s++) begin
      for (int w = 0; w < int'(NW); w++) begin
        if (v_d[s][w]) begin
          i_q[s][w] <= i_d[s][w];
          d_q[s][w] <= d_d[s][w];
        end
      end
    end
  end

  assign st_vld  = v_q;
  assign st_idx  = i_q;
  assign st_data = d_q;

endmodule

// File: rtl/prf_store.sv
module prf_store #(
  parameter int unsigned ENTRIES = 160,
  parameter int unsigned NW      = 4,
  parameter int unsigned NR      = 8,
  parameter int unsigned IW      = 8,
  parameter int unsigned DW      = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NW-1:0]           we,
  input  logic [NW-1:0][IW-1:0]   widx,
  input  logic [NW-1:0][DW-1:0]   wdata,
  input  logic [NR-1:0][IW-1:0]   ridx,
  output logic [NR-1:0][DW-1:0]   rdata
);

  localparam logic [IW:0] LIMIT = ENTRIES[IW:0];

  logic [DW-1:0]      mem   [ENTRIES];
  logic [DW-1:0]      row_d [ENTRIES];
  logic [ENTRIES-1:0] row_en;

  // Row decode: at most one write port hits any row per cycle.
  always_comb begin
    for (int r = 0; r < int'(ENTRIES); r++) begin
      row_en[r] = 1'b0;
      row_d[r]  = '0;
      for (int w = 0; w < int'(NW); w++) begin
        if (we[w] && (widx[w] == IW'(r))) begin
          row_en[r] = 1'b1;
          row_d[r]  = wdata[w];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ENTRIES); r++) begin
        mem[r] <= '0;
      end
    end else begin
      for (int r = 0; r < int'(ENTRIES); r++) begin
        if (row_en[r]) begin
          mem[r] <= row_d[r];
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < int'(NR); p++) begin
      rdata[p] = '0;
      if ({1'b0, ridx[p]} < LIMIT) begin
        rdata[p] = mem[ridx[p]];
      end
    end
  end

endmodule

// File: rtl/prf_rd_stage.sv
module prf_rd_stage #(
  parameter int unsigned NW = 4,
  parameter int unsigned IW = 8,
  parameter int unsigned DW = 64,
  parameter int unsigned NK = 3
) (
  input  logic                              r_vld,
  input  logic [IW-1:0]                     r_idx,
  input  logic [DW-1:0]                     base,
  input  logic [NK-1:0][NW-1:0]             w_vld,
  input  logic [NK-1:0][NW-1:0][IW-1:0]     w_idx,
  input  logic [NK-1:0][NW-1:0][DW-1:0]     w_data,
  output logic [DW-1:0]                     merged
);

  // Element 0 is the youngest write stage visible here. Walk from the
  // oldest to the youngest so the youngest match is applied last.
  always_comb begin
    merged = base;
    for (int k = int'(NK) - 1; k >= 0; k--) begin
      for (int w = 0; w < int'(NW); w++) begin
        if (r_vld && w_vld[k][w] && (w_idx[k][w] == r_idx)) begin
          merged = w_data[k][w];
        end
      end
    end
  end

endmodule

// File: rtl/staged_regfile.sv
module staged_regfile
  import sfr_pkg::*;
#(
  parameter int unsigned ENTRIES = 160,
  parameter int unsigned DW      = 64,
  parameter int unsigned NR      = 8,
  parameter int unsigned NW      = 4,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NR-1:0]    rd_vld,
  input  logic [NR*IW-1:0] rd_idx,
  input  logic [NW-1:0]    wr_vld,
  input  logic [NW*IW-1:0] wr_idx,
  input  logic [NW*DW-1:0] wr_data,
  output logic [NR-1:0]    rd_ok,
  output logic [NR*DW-1:0] rd_data
);

  localparam logic [IW:0] LIMIT = ENTRIES[IW:0];

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sq;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sq <= '0;
    end else begin
      rst_sq <= {rst_sq[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sq[1];

  // Port unpacking and range qualification.
  logic [NW-1:0]           wq_vld;
  logic [NW-1:0][IW-1:0]   wq_idx;
  logic [NW-1:0][DW-1:0]   wq_data;
  logic [NR-1:0]           rq_vld;
  logic [NR-1:0][IW-1:0]   rq_idx;

  for (genvar w = 0; w < NW; w++) begin : g_wq
    assign wq_idx[w]  = wr_idx[w*IW +: IW];
    assign wq_data[w] = wr_data[w*DW +: DW];
    assign wq_vld[w]  = wr_vld[w] && ({1'b0, wq_idx[w]} < LIMIT);
  end

  for (genvar p = 0; p < NR; p++) begin : g_rq
    assign rq_idx[p] = rd_idx[p*IW +: IW];
    assign rq_vld[p] = rd_vld[p] && ({1'b0, rq_idx[p]} < LIMIT);
  end

  // Write pipeline and storage.
  logic [STAGES-1:0][NW-1:0]         ws_vld;
  logic [STAGES-1:0][NW-1:0][IW-1:0] ws_idx;
  logic [STAGES-1:0][NW-1:0][DW-1:0] ws_data;
  logic [NR-1:0][DW-1:0]             arr_rd;

  prf_wr_pipe #(
    .NW (NW),
    .IW (IW),
    .DW (DW)
  ) u_wpipe (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_vld  (wq_vld),
    .in_idx  (wq_idx),
    .in_data (wq_data),
    .st_vld  (ws_vld),
    .st_idx  (ws_idx),
    .st_data (ws_data)
  );

  prf_store #(
    .ENTRIES (ENTRIES),
    .NW      (NW),
    .NR      (NR),
    .IW      (IW),
    .DW      (DW)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (ws_vld[STAGES-1]),
    .widx  (ws_idx[STAGES-1]),
    .wdata (ws_data[STAGES-1]),
    .ridx  (rq_idx),
    .rdata (arr_rd)
  );

  // Read pipelines, one per port.
  for (genvar p = 0; p < NR; p++) begin : g_rd
    logic [STAGES-1:0]         sv;
    logic [STAGES-1:0][IW-1:0] si;
    logic [DW-1:0]             sb [STAGES];
    logic [DW-1:0]             sm [STAGES];

    logic [STAGES-1:1]         rv_d, rv_q;
    logic [STAGES-1:1][IW-1:0] ri_d, ri_q;
    logic [STAGES-1:1][DW-1:0] rb_d, rb_q;
    logic                      ok_d, ok_q;
    logic [DW-1:0]             od_d, od_q;

    // Per-stage view: stage 0 is the port itself, deeper stages registered.
    always_comb begin
      sv[0] = rq_vld[p];
      si[0] = rq_idx[p];
      sb[0] = arr_rd[p];
      for (int s = 1; s < int'(STAGES); s++) begin
        sv[s] = rv_q[s];
        si[s] = ri_q[s];
        sb[s] = rb_q[s];
      end
    end

    // Read stage s sees write stages s and deeper.
    for (genvar s = 0; s < STAGES; s++) begin : g_st
      prf_rd_stage #(
        .NW (NW),
        .IW (IW),
        .DW (DW),
        .NK (STAGES - s)
      ) u_mrg (
        .r_vld  (sv[s]),
        .r_idx  (si[s]),
        .base   (sb[s]),
        .w_vld  (ws_vld[STAGES-1:s]),
        .w_idx  (ws_idx[STAGES-1:s]),
        .w_data (ws_data[STAGES-1:s]),
        .merged (sm[s])
      );
    end

    always_comb begin
      for (int s = 1; s < int'(STAGES); s++) begin
        rv_d[s] = sv[s-1];
        ri_d[s] = si[s-1];
        rb_d[s] = sm[s-1];
      end
      ok_d = sv[STAGES-1];
      od_d = sv[STAGES-1] ? sm[STAGES-1] : '0;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        rv_q <= '0;
        ok_q <= 1'b0;
        od_q <= '0;
      end else begin
        rv_q <= rv_d;
        ok_q <= ok_d;
        od_q <= od_d;
      end
    end

    always_ff @(posedge clk) begin
      for (int s = 1; s < int'(STAGES); s++) begin
        if (rv_d[s]) begin
          ri_q[s] <= ri_d[s];
          rb_q[s] <= rb_d[s];
        end
      end
    end

    assign rd_ok[p]            = ok_q;
    assign rd_data[p*DW +: DW] = od_q;
  end

endmodule

// File: rtl/prf_chk.sv
module prf_chk #(
  parameter int unsigned ENTRIES = 160,
  parameter int unsigned DW      = 64,
  parameter int unsigned NR      = 8,
  parameter int unsigned NW      = 4,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [NR-1:0]    rd_vld,
  input logic [NR*IW-1:0] rd_idx,
  input logic [NW-1:0]    wr_vld,
  input logic [NW*IW-1:0] wr_idx,
  input logic [NR-1:0]    rd_ok,
  input logic [NR*DW-1:0] rd_data
);

  localparam logic [IW:0] LIMIT = ENTRIES[IW:0];

  // Edges seen since reset release, saturating.
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      since_rst <= '0;
    end else if (since_rst != 3'd7) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  for (genvar a = 0; a < NW; a++) begin : g_wa
    for (genvar b = a + 1; b < NW; b++) begin : g_wb
      // R9
      wr_idx_unique_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !(wr_vld[a] && wr_vld[b] && ({1'b0, wr_idx[a*IW +: IW]} < LIMIT) &&
          (wr_idx[a*IW +: IW] == wr_idx[b*IW +: IW])));
    end
  end

  for (genvar p = 0; p < NR; p++) begin : g_rp
    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (since_rst >= 3'd3) |->
        (rd_ok[p] == $past(rd_vld[p] && ({1'b0, rd_idx[p*IW +: IW]} < LIMIT), 3)));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !rd_ok[p] |-> (rd_data[p*DW +: DW] == '0));

    // R3
    repeat_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((since_rst >= 3'd5) && rd_ok[p] && $past(rd_ok[p]) &&
       ($past(rd_idx[p*IW +: IW], 3) == $past(rd_idx[p*IW +: IW], 4)) &&
       ($past(wr_vld, 4) == '0)) |->
        (rd_data[p*DW +: DW] == $past(rd_data[p*DW +: DW])));
  end

endmodule

bind staged_regfile prf_chk #(
  .ENTRIES (ENTRIES),
  .DW      (DW),
  .NR      (NR),
  .NW      (NW)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_vld     (rd_vld),
  .rd_idx     (rd_idx),
  .wr_vld     (wr_vld),
  .wr_idx     (wr_idx),
  .rd_ok      (rd_ok),
  .rd_data    (rd_data)
);

// File: tb/test_staged_regfile.sv
module test_staged_regfile;

  localparam int ENT = 160;
  localparam int DW  = 64;
  localparam int NR  = 8;
  localparam int NW  = 4;
  localparam int IW  = $clog2(ENT);

  logic             clk;
  logic             rst_n;
  logic [NR-1:0]    rd_vld;
  logic [NR*IW-1:0] rd_idx;
  logic [NW-1:0]    wr_vld;
  logic [NW*IW-1:0] wr_idx;
  logic [NW*DW-1:0] wr_data;
  logic [NR-1:0]    rd_ok;
  logic [NR*DW-1:0] rd_data;

  staged_regfile #(
    .ENTRIES (ENT),
    .DW      (DW),
    .NR      (NR),
    .NW      (NW)
  ) i_staged_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_vld  (rd_vld),
    .rd_idx  (rd_idx),
    .wr_vld  (wr_vld),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_ok   (rd_ok),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference state: value per entry plus the cycles of its last two writes.
  logic [DW-1:0] m_mem [ENT];
  int            last_wc [ENT];
  int            prev_wc [ENT];
  int            cyc;
  logic          e_ok  [4][NR];
  logic [DW-1:0] e_dat [4][NR];
  string         e_tag [4][NR];

  bit            dv_r [NR];
  int            di_r [NR];
  bit            dv_w [NW];
  int            di_w [NW];
  logic [DW-1:0] dd_w [NW];
  string         ovr;

  int checks;
  int errors;
  bit done;

  task automatic chk(input bit good, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b0; di_r[p] = 0; end
    for (int w = 0; w < NW; w++) begin dv_w[w] = 1'b0; di_w[w] = 0; dd_w[w] = '0; end
    ovr = "";
  endtask

  // One cycle: check the result due now, predict the new reads, drive, update.
  task automatic step();
    int s;
    int n;
    @(negedge clk);
    if (cyc >= 3) begin
      s = (cyc - 3) % 4;
      for (int p = 0; p < NR; p++) begin
        chk(rd_ok[p] === e_ok[s][p], e_tag[s][p], DW'(rd_ok[p]), DW'(e_ok[s][p]));
        chk(rd_data[p*DW +: DW] === e_dat[s][p], e_tag[s][p],
            rd_data[p*DW +: DW], e_dat[s][p]);
      end
    end
    n = cyc % 4;
    for (int p = 0; p < NR; p++) begin
      int  i;
      bit  same;
      i = di_r[p];
      if (dv_r[p] && (i < ENT)) begin
        e_ok[n][p]  = 1'b1;
        e_dat[n][p] = m_mem[i];
        same = 1'b0;
        for (int w = 0; w < NW; w++) begin
          if (dv_w[w] && (di_w[w] == i)) same = 1'b1;
        end
        if (same)                          e_tag[n][p] = "R6";
        else if (cyc - prev_wc[i] <= 3)    e_tag[n][p] = "R7";
        else if (last_wc[i] < 0)           e_tag[n][p] = "R1";
        else if (cyc - last_wc[i] == 1)    e_tag[n][p] = "R3";
        else if (cyc - last_wc[i] <= 3)    e_tag[n][p] = "R4";
        else                               e_tag[n][p] = "R5";
      end else begin
        e_ok[n][p]  = 1'b0;
        e_dat[n][p] = '0;
        e_tag[n][p] = dv_r[p] ? "R8" : "R2";
      end
      if (ovr != "") e_tag[n][p] = ovr;
      rd_vld[p]            = dv_r[p];
      rd_idx[p*IW +: IW]   = di_r[p][IW-1:0];
    end
    for (int w = 0; w < NW; w++) begin
      wr_vld[w]            = dv_w[w];
      wr_idx[w*IW +: IW]   = di_w[w][IW-1:0];
      wr_data[w*DW +: DW]  = dd_w[w];
      if (dv_w[w] && (di_w[w] < ENT)) begin
        m_mem[di_w[w]]   = dd_w[w];
        prev_wc[di_w[w]] = last_wc[di_w[w]];
        last_wc[di_w[w]] = cyc;
      end
    end
    cyc++;
  endtask

  function automatic int pick();
    if ($urandom_range(99) < 70) return 40 + int'($urandom_range(7));
    return int'($urandom_range(255));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, got no completion expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    cyc    = 0;
    rst_n  = 1'b0;
    rd_vld = '0; rd_idx = '0; wr_vld = '0; wr_idx = '0; wr_data = '0;
    for (int i = 0; i < ENT; i++) begin
      m_mem[i] = '0; last_wc[i] = -100; prev_wc[i] = -100;
    end
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: outputs idle after reset
    chk(rd_ok === '0, "R1", DW'(rd_ok), '0);
    chk(rd_data === '0, "R1", rd_data[DW-1:0], '0);

    // R1: every entry reads zero before any write
    for (int k = 0; k < ENT / NR; k++) begin
      clr();
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = k * NR + p; end
      step();
    end

    // R6, R3, R4, R5: one write, then reads of its index at ages 0..5
    clr();
    dv_w[0] = 1'b1; di_w[0] = 9; dd_w[0] = 64'hA5A5_0123_4567_89AB;
    for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = 9; end
    step();
    for (int k = 1; k <= 5; k++) begin
      clr();
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = 9; end
      step();
    end

    // R7: three back-to-back writes to one index from different ports
    for (int k = 0; k < 3; k++) begin
      clr();
      dv_w[k] = 1'b1; di_w[k] = 9; dd_w[k] = 64'h7000_0000_0000_0000 + DW'(k);
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = 9; end
      step();
    end
    for (int k = 0; k < 4; k++) begin
      clr();
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = 9; end
      step();
    end

    // R9: all write ports at once, then all read ports
    clr();
    ovr = "R9";
    for (int w = 0; w < NW; w++) begin
      dv_w[w] = 1'b1; di_w[w] = 20 + w; dd_w[w] = {$urandom, $urandom};
    end
    step();
    for (int k = 0; k < 2; k++) begin
      clr();
      ovr = "R9";
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = 20 + (p % NW); end
      step();
    end

    // R8: out-of-range writes and reads next to in-range ones
    clr();
    for (int w = 0; w < NW; w++) begin
      dv_w[w] = 1'b1; di_w[w] = 160 + w * 30; dd_w[w] = '1;
    end
    for (int p = 0; p < NR; p++) begin
      dv_r[p] = 1'b1; di_r[p] = (p < 4) ? 200 + p * 10 : p;
    end
    step();
    for (int k = 0; k < 4; k++) begin
      clr();
      ovr = "R8";
      for (int p = 0; p < NR; p++) begin dv_r[p] = 1'b1; di_r[p] = (p < 4) ? 255 : p; end
      step();
    end

    // Random traffic concentrated on a small index window
    for (int k = 0; k < 3000; k++) begin
      clr();
      for (int p = 0; p < NR; p++) begin
        dv_r[p] = ($urandom_range(99) < 80);
        di_r[p] = pick();
      end
      for (int w = 0; w < NW; w++) begin
        dv_w[w] = ($urandom_range(99) < 60);
        di_w[w] = pick();
        dd_w[w] = {$urandom, $urandom};
        for (int v = 0; v < w; v++) begin
          if (dv_w[v] && (di_w[v] == di_w[w])) dv_w[w] = 1'b0;
        end
      end
      step();
    end

    // Drain remaining results
    for (int k = 0; k < 4; k++) begin
      clr();
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule